// File: doc/BRIEF.md
# Coherence History Consistency Checker

This block audits per-line coherence state histories gathered during silicon bring-up. Recorders elsewhere keep, for each cache line, a short history of protocol states: one in the shared second-level cache and one in each private first-level cache. When a history fills up, or a programmable cycle interval runs out, the checker walks every line index in ascending order. It reads the histories through a simple indexed read port and decides whether each private history fits the shared one.

The shared history is taken as a literal string. Each private history is taken as a pattern in which an Invalid symbol stands for any run of shared symbols, including an empty run. Both sides are first rewritten to remove effects the shared cache cannot see: repeated symbols, Exclusive-to-Modified upgrades and contention ping-pong. When a private pattern starts with Invalid then Modified, a second reading with an Exclusive in place of that Modified is also tried, and the line passes if either reading matches. A failing line raises a sticky error and freezes a debug snapshot. The end-of-walk pulse tells the recorders to reseed.

Top module: `coh_hist_chk`

## Requirements
- R1: Symbols are 3-bit codes (0 empty, 1 I, 2 S, 3 E, 4 M). Symbol k of a history sits at bits [3k+2:3k], with k=0 the newest, and empty slots lie above the used ones. A private history matches when its Invalid entries, each standing for any run of shared symbols, make it equal to the whole shared string.
- R2: Runs of equal consecutive symbols are reduced to one symbol, in the shared history and in every private history, before matching.
- R3: In a private history, any M that directly follows an E is dropped, so E M reads as E.
- R4: In a private history, M I M reads as M, and an alternation M I M I that ends the history reads as M.
- R5: A private history takes part only when its tag equals the shared tag of the line and it is not empty. Other private histories cannot cause a mismatch.
- R6: A private pattern that starts with I then M is also tried with E in place of that M. The line passes if either reading matches.
- R7: A line is checked, and reported, only when its newest shared symbol is neither empty nor I.
- R8: A walk starts on a full_i pulse, or when interval_i (if non-zero) cycles have passed since the last walk started. It visits the lines in ascending index order and ends with a one-cycle done_o and reseed_o pulse. With interval_i at zero and no full_i, no walk starts.
- R9: Each checked line gives a one-cycle line_vld_o with its index and verdict. A mismatch sets err_o, which stays set until reset, and captures the line index, the shared tag and both raw histories in the debug outputs.
- R10: After reset, busy_o, err_o, done_o and line_vld_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| interval_i | input | CNT_W | Cycles between timed walks, 0 disables timed walks |
| full_i | input | 1 | Pulse: some history filled up |
| idx_o | output | IDX_W | Line index being read |
| l2_hist_i | input | DEPTH*3 | Shared history of line idx_o |
| l2_tag_i | input | TAG_W | Shared tag of line idx_o |
| l1_hist_i | input | N_L1*DEPTH*3 | Private histories, cache j at slice j |
| l1_tag_i | input | N_L1*TAG_W | Private tags, cache j at slice j |
| busy_o | output | 1 | Walk in progress |
| line_vld_o | output | 1 | Verdict for a checked line |
| line_ok_o | output | 1 | Verdict: 1 consistent |
| line_idx_o | output | IDX_W | Line the verdict belongs to |
| done_o | output | 1 | Walk finished |
| reseed_o | output | 1 | Recorders may restart their histories |
| err_o | output | 1 | Sticky mismatch flag |
| dbg_idx_o | output | IDX_W | Index of the last failing line |
| dbg_tag_o | output | TAG_W | Shared tag of the last failing line |
| dbg_l2_o | output | DEPTH*3 | Raw shared history of the last failing line |
| dbg_l1_o | output | N_L1*DEPTH*3 | Raw private histories of the last failing line |

## Verification
The hardest cases to reach from the ports are those where a rewrite rule alone decides the verdict. Examples are a private history that matches only after E M is folded, or only after the ping-pong collapse, or only through the second E reading of a leading I M. The bench builds these histories from short symbol strings in a line memory model. For each rule it pairs the history with a shared string that the raw pattern would fail against, so a missing rule turns into a wrong verdict at line_ok_o. Tag mismatches and skipped lines are placed on the same walk next to lines that must report, so a suppressed or extra report shows up in the per-line record.

// File: rtl/coh_hist_pkg.sv
package coh_hist_pkg;
  localparam int SYM_W = 3;
  localparam logic [SYM_W-1:0] SYM_NONE = 3'd0;
  localparam logic [SYM_W-1:0] SYM_I    = 3'd1;
  localparam logic [SYM_W-1:0] SYM_S    = 3'd2;
  localparam logic [SYM_W-1:0] SYM_E    = 3'd3;
  localparam logic [SYM_W-1:0] SYM_M    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_NORM, ST_MATCH, ST_REPORT
  } chk_state_e;
endpackage

// File: rtl/coh_hist_norm.sv
// Rewrites a raw history (newest at slot 0) into an oldest-first string.
module coh_hist_norm
  import coh_hist_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter bit IS_L1 = 1'b1,
  localparam int HIST_W = DEPTH * SYM_W,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic [HIST_W-1:0] raw_i,
  output logic [HIST_W-1:0] str_o,
  output logic [LEN_W-1:0]  len_o
);
  always_comb begin
    logic [SYM_W-1:0] s, last;
    logic pend, alt, take;
    int n;
    str_o = '0;
    n = 0;
    last = SYM_NONE;
    pend = 1'b0;
    alt = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      s = raw_i[i*SYM_W +: SYM_W];
      take = (s != SYM_NONE);
      if (take && IS_L1 && pend) begin
        if (s == SYM_M) begin          // M I M -> M
          pend = 1'b0;
          alt = 1'b1;
          take = 1'b0;
        end else if (s == SYM_I) begin
          take = 1'b0;
        end else begin                 // lone M I: keep the I
          if (n < DEPTH) str_o[n*SYM_W +: SYM_W] = SYM_I;
          n++;
          last = SYM_I;
          pend = 1'b0;
          alt = 1'b0;
        end
      end
      if (take) begin
        if (n != 0 && s == last) begin
        end else if (IS_L1 && last == SYM_E && s == SYM_M) begin
        end else if (IS_L1 && last == SYM_M && s == SYM_I) begin
          pend = 1'b1;
        end else begin
          if (n < DEPTH) str_o[n*SYM_W +: SYM_W] = s;
          n++;
          last = s;
          alt = 1'b0;
        end
      end
    end
    if (pend && !alt) begin
      if (n < DEPTH) str_o[n*SYM_W +: SYM_W] = SYM_I;
      n++;
    end
    len_o = LEN_W'(n);
  end
endmodule

// File: rtl/coh_hist_glob.sv
// One pattern step of wildcard matching; bit j = prefix of length j matched.
module coh_hist_glob
  import coh_hist_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int HIST_W = DEPTH * SYM_W
) (
  input  logic [DEPTH:0]     cur_i,
  input  logic [SYM_W-1:0]   sym_i,
  input  logic               skip_i,
  input  logic [HIST_W-1:0]  str_i,
  output logic [DEPTH:0]     nxt_o
);
  always_comb begin
    logic acc;
    acc = 1'b0;
    nxt_o = '0;
    if (skip_i) begin
      nxt_o = cur_i;
    end else if (sym_i == SYM_I) begin
      for (int j = 0; j <= DEPTH; j++) begin
        acc = acc | cur_i[j];
        nxt_o[j] = acc;
      end
    end else begin
      for (int j = 1; j <= DEPTH; j++)
        nxt_o[j] = cur_i[j-1] && (str_i[(j-1)*SYM_W +: SYM_W] == sym_i);
    end
  end
endmodule

// File: rtl/coh_hist_trig.sv
module coh_hist_trig #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             full_i,
  input  logic             idle_i,
  output logic             go_o
);
  logic [CNT_W-1:0] cnt_q;
  logic pend_q, expire;

  assign expire = (interval_i != '0) && (cnt_q >= interval_i - CNT_W'(1));
  assign go_o   = idle_i && (pend_q || full_i || expire);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (go_o) cnt_q <= '0;
      else if (!expire) cnt_q <= cnt_q + CNT_W'(1);
      if (go_o) pend_q <= 1'b0;
      else if (full_i) pend_q <= 1'b1;
    end
  end
endmodule

// File: rtl/coh_hist_chk.sv
module coh_hist_chk
  import coh_hist_pkg::*;
#(
  parameter int N_L1    = 2,
  parameter int N_LINES = 4,
  parameter int DEPTH   = 8,
  parameter int TAG_W   = 8,
  parameter int CNT_W   = 16,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int HIST_W = DEPTH * SYM_W,
  localparam int LEN_W  = $clog2(DEPTH + 1),
  localparam int J_W    = $clog2(N_L1 + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        interval_i,
  input  logic                    full_i,
  output logic [IDX_W-1:0]        idx_o,
  input  logic [HIST_W-1:0]       l2_hist_i,
  input  logic [TAG_W-1:0]        l2_tag_i,
  input  logic [N_L1*HIST_W-1:0]  l1_hist_i,
  input  logic [N_L1*TAG_W-1:0]   l1_tag_i,
  output logic                    busy_o,
  output logic                    line_vld_o,
  output logic                    line_ok_o,
  output logic [IDX_W-1:0]        line_idx_o,
  output logic                    done_o,
  output logic                    reseed_o,
  output logic                    err_o,
  output logic [IDX_W-1:0]        dbg_idx_o,
  output logic [TAG_W-1:0]        dbg_tag_o,
  output logic [HIST_W-1:0]       dbg_l2_o,
  output logic [N_L1*HIST_W-1:0]  dbg_l1_o
);
  chk_state_e state_q;
  logic [IDX_W-1:0]       line_q;
  logic [J_W-1:0]         j_q;
  logic [LEN_W-1:0]       k_q;
  logic                   ok_q, chk_q, err_q, go;
  logic [HIST_W-1:0]      l2_raw_q;
  logic [TAG_W-1:0]       l2_tag_q;
  logic [N_L1*HIST_W-1:0] l1_raw_q;
  logic [N_L1*TAG_W-1:0]  l1_tag_q;
  logic [N_L1-1:0]        part_q;
  logic [DEPTH:0]         dm_q, da_q, dm_nxt, da_nxt;

  logic [HIST_W-1:0] l2n_w;
  logic [LEN_W-1:0]  l2len_w;
  logic [HIST_W-1:0] pn_w [N_L1];
  logic [LEN_W-1:0]  plen_w [N_L1];

  coh_hist_trig #(.CNT_W(CNT_W)) u_trig (
    .clk_i, .rst_ni, .interval_i, .full_i,
    .idle_i(state_q == ST_IDLE), .go_o(go)
  );

  coh_hist_norm #(.DEPTH(DEPTH), .IS_L1(1'b0)) u_norm_l2 (
    .raw_i(l2_raw_q), .str_o(l2n_w), .len_o(l2len_w)
  );

  for (genvar g = 0; g < N_L1; g++) begin : g_l1
    coh_hist_norm #(.DEPTH(DEPTH), .IS_L1(1'b1)) u_norm (
      .raw_i(l1_raw_q[g*HIST_W +: HIST_W]), .str_o(pn_w[g]), .len_o(plen_w[g])
    );
  end

  // pattern symbol feed for the literal and the E-substituted reading
  logic [HIST_W-1:0] pat;
  logic [LEN_W-1:0]  plen;
  logic [SYM_W-1:0]  p_sym, p_prev, a_sym, a_prev;
  logic              a_skip, alt_v, res, last_j, last_line;

  always_comb begin
    pat    = pn_w[j_q];
    plen   = plen_w[j_q];
    p_sym  = SYM_NONE;
    p_prev = SYM_NONE;
    if (int'(k_q) < DEPTH) p_sym = pat[int'(k_q)*SYM_W +: SYM_W];
    if (k_q != '0) p_prev = pat[(int'(k_q)-1)*SYM_W +: SYM_W];
    a_sym  = (k_q == LEN_W'(1)) ? SYM_E : p_sym;
    a_prev = (k_q == LEN_W'(2)) ? SYM_E : p_prev;
    a_skip = (k_q != '0) && (a_sym == a_prev);
    alt_v  = (pat[SYM_W-1:0] == SYM_I) && (pat[2*SYM_W-1:SYM_W] == SYM_M);
    res    = dm_q[l2len_w] | (alt_v & da_q[l2len_w]);
  end

  coh_hist_glob #(.DEPTH(DEPTH)) u_glob_lit (
    .cur_i(dm_q), .sym_i(p_sym), .skip_i(1'b0), .str_i(l2n_w), .nxt_o(dm_nxt)
  );
  coh_hist_glob #(.DEPTH(DEPTH)) u_glob_alt (
    .cur_i(da_q), .sym_i(a_sym), .skip_i(a_skip), .str_i(l2n_w), .nxt_o(da_nxt)
  );

  assign last_j    = (j_q == J_W'(N_L1 - 1));
  assign last_line = (line_q == IDX_W'(N_LINES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      line_q    <= '0;
      j_q       <= '0;
      k_q       <= '0;
      ok_q      <= 1'b0;
      chk_q     <= 1'b0;
      err_q     <= 1'b0;
      l2_raw_q  <= '0;
      l2_tag_q  <= '0;
      l1_raw_q  <= '0;
      l1_tag_q  <= '0;
      part_q    <= '0;
      dm_q      <= '0;
      da_q      <= '0;
      dbg_idx_o <= '0;
      dbg_tag_o <= '0;
      dbg_l2_o  <= '0;
      dbg_l1_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (go) begin
          line_q  <= '0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          l2_raw_q <= l2_hist_i;
          l2_tag_q <= l2_tag_i;
          l1_raw_q <= l1_hist_i;
          l1_tag_q <= l1_tag_i;
          state_q  <= ST_NORM;
        end
        ST_NORM: begin
          for (int j = 0; j < N_L1; j++)
            part_q[j] <= (l1_tag_q[j*TAG_W +: TAG_W] == l2_tag_q) && (plen_w[j] != '0);
          chk_q   <= (l2_raw_q[SYM_W-1:0] != SYM_NONE) && (l2_raw_q[SYM_W-1:0] != SYM_I);
          ok_q    <= 1'b1;
          j_q     <= '0;
          k_q     <= '0;
          dm_q    <= (DEPTH+1)'(1);
          da_q    <= (DEPTH+1)'(1);
          state_q <= ((l2_raw_q[SYM_W-1:0] != SYM_NONE) && (l2_raw_q[SYM_W-1:0] != SYM_I))
                     ? ST_MATCH : ST_REPORT;
        end
        ST_MATCH: begin
          if (part_q[j_q] && k_q < plen) begin
            dm_q <= dm_nxt;
            da_q <= da_nxt;
            k_q  <= k_q + LEN_W'(1);
          end else begin
            if (part_q[j_q]) ok_q <= ok_q & res;
            dm_q <= (DEPTH+1)'(1);
            da_q <= (DEPTH+1)'(1);
            k_q  <= '0;
            j_q  <= j_q + J_W'(1);
            if (last_j) state_q <= ST_REPORT;
          end
        end
        ST_REPORT: begin
          if (chk_q && !ok_q) begin
            err_q     <= 1'b1;
            dbg_idx_o <= line_q;
            dbg_tag_o <= l2_tag_q;
            dbg_l2_o  <= l2_raw_q;
            dbg_l1_o  <= l1_raw_q;
          end
          if (last_line) state_q <= ST_IDLE;
          else begin
            line_q  <= line_q + IDX_W'(1);
            state_q <= ST_LOAD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o      = line_q;
  assign busy_o     = (state_q != ST_IDLE);
  assign line_vld_o = (state_q == ST_REPORT) && chk_q;
  assign line_ok_o  = ok_q;
  assign line_idx_o = line_q;
  assign done_o     = (state_q == ST_REPORT) && last_line;
  assign reseed_o   = done_o;
  assign err_o      = err_q;
endmodule

// File: rtl/coh_hist_chk_sva.sv
module coh_hist_chk_sva #(
  parameter int IDX_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             line_vld_o,
  input logic             line_ok_o,
  input logic             done_o,
  input logic             err_o,
  input logic [IDX_W-1:0] dbg_idx_o
);
  // R8: end-of-walk pulse lasts one cycle and returns to idle
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  a_r8_vld_in_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_vld_o |-> busy_o);
  // R9: sticky error and frozen debug snapshot
  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  a_r9_err_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_vld_o && !line_ok_o) |=> err_o);
  a_r9_dbg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(line_vld_o && !line_ok_o) |=> $stable(dbg_idx_o));
endmodule

bind coh_hist_chk coh_hist_chk_sva #(.IDX_W(IDX_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .line_vld_o(line_vld_o),
  .line_ok_o(line_ok_o), .done_o(done_o), .err_o(err_o), .dbg_idx_o(dbg_idx_o)
);

// File: tb/coh_hist_chk_tb_top.sv
`timescale 1ns/1ps
module coh_hist_chk_tb_top;
  localparam int N_L1 = 2, N_LINES = 4, DEPTH = 8, TAG_W = 8, CNT_W = 16;
  localparam int HW = DEPTH * 3;

  logic clk = 1'b0, rst_n = 1'b0, full = 1'b0;
  logic [CNT_W-1:0] interval = '0;
  logic [1:0] idx, line_idx, dbg_idx;
  logic [HW-1:0] l2_hist, dbg_l2;
  logic [TAG_W-1:0] l2_tag, dbg_tag;
  logic [N_L1*HW-1:0] l1_hist, dbg_l1;
  logic [N_L1*TAG_W-1:0] l1_tag;
  logic busy, vld, ok, done, reseed, err;

  logic [HW-1:0] m_l2 [N_LINES];
  logic [TAG_W-1:0] m_l2t [N_LINES];
  logic [HW-1:0] m_l1 [N_LINES][N_L1];
  logic [TAG_W-1:0] m_l1t [N_LINES][N_L1];

  int n_chk = 0, n_fail = 0, n_done = 0;
  bit seen [N_LINES];
  bit okv [N_LINES];

  always #2.5 clk = ~clk;

  coh_hist_chk #(.N_L1(N_L1), .N_LINES(N_LINES), .DEPTH(DEPTH), .TAG_W(TAG_W),
                 .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .interval_i(interval), .full_i(full),
    .idx_o(idx), .l2_hist_i(l2_hist), .l2_tag_i(l2_tag), .l1_hist_i(l1_hist),
    .l1_tag_i(l1_tag), .busy_o(busy), .line_vld_o(vld), .line_ok_o(ok),
    .line_idx_o(line_idx), .done_o(done), .reseed_o(reseed), .err_o(err),
    .dbg_idx_o(dbg_idx), .dbg_tag_o(dbg_tag), .dbg_l2_o(dbg_l2), .dbg_l1_o(dbg_l1)
  );

  always_comb begin
    l2_hist = m_l2[idx];
    l2_tag  = m_l2t[idx];
    for (int j = 0; j < N_L1; j++) begin
      l1_hist[j*HW +: HW]       = m_l1[idx][j];
      l1_tag[j*TAG_W +: TAG_W]  = m_l1t[idx][j];
    end
  end

  always @(negedge clk) begin
    if (vld) begin
      seen[line_idx] = 1'b1;
      okv[line_idx]  = ok;
    end
    if (done) n_done++;
  end

  // oldest symbol first in the string
  function automatic logic [HW-1:0] mk(string s);
    logic [HW-1:0] h = '0;
    for (int i = 0; i < s.len(); i++) begin
      logic [2:0] c;
      case (s[i])
        "I": c = 3'd1;
        "S": c = 3'd2;
        "E": c = 3'd3;
        "M": c = 3'd4;
        default: c = 3'd0;
      endcase
      h[(s.len()-1-i)*3 +: 3] = c;
    end
    return h;
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < N_LINES; i++) begin
      m_l2[i] = '0;
      m_l2t[i] = 8'h05;
      for (int j = 0; j < N_L1; j++) begin
        m_l1[i][j] = '0;
        m_l1t[i][j] = 8'hEE;
      end
    end
  endtask

  task automatic set_line(int i, string l2, string a, string b, logic [7:0] tb_tag);
    m_l2[i] = mk(l2);
    m_l1[i][0] = mk(a);
    m_l1[i][1] = mk(b);
    m_l1t[i][0] = (a.len() != 0) ? 8'h05 : 8'hEE;
    m_l1t[i][1] = tb_tag;
  endtask

  task automatic walk(string req);
    int d0, t;
    for (int i = 0; i < N_LINES; i++) begin
      seen[i] = 1'b0;
      okv[i] = 1'b0;
    end
    d0 = n_done;
    @(negedge clk) full = 1'b1;
    @(negedge clk) full = 1'b0;
    t = 0;
    while (n_done == d0 && t < 2000) begin
      @(negedge clk);
      t++;
    end
    check({req, " walk done"}, longint'(n_done - d0), 1);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 busy", busy, 0);
    check("R10 err", err, 0);
    check("R10 done", done, 0);
    check("R10 vld", vld, 0);
  endtask

  task automatic t_wildcard();
    clear_mem();
    set_line(0, "ESM", "ISM", "IEI", 8'h05);
    set_line(1, "SE", "ISIM", "", 8'hEE);
    walk("R1");
    check("R1 line0 seen", seen[0], 1);
    check("R1 line0 ok", okv[0], 1);
    check("R1 line1 seen", seen[1], 1);
    check("R1 line1 mismatch", okv[1], 0);
    check("R9 err set", err, 1);
    check("R9 dbg idx", dbg_idx, 1);
    check("R9 dbg tag", dbg_tag, 8'h05);
    check("R9 dbg l2", dbg_l2, mk("SE"));
    check("R9 dbg l1", dbg_l1[HW-1:0], mk("ISIM"));
  endtask

  task automatic t_rules();
    clear_mem();
    set_line(0, "ESMM", "ISMM", "", 8'hEE);      // R2
    set_line(1, "SE", "IEM", "", 8'hEE);         // R3
    set_line(2, "SM", "ISMIMIM", "ISMIMI", 8'h05); // R4
    set_line(3, "ESM", "ISM", "ISIE", 8'h06);    // R5: second cache tag differs
    walk("R2 R3 R4 R5");
    check("R2 dup collapse", okv[0], 1);
    check("R3 E M fold", okv[1], 1);
    check("R4 ping-pong fold", okv[2], 1);
    check("R5 tag filter", okv[3], 1);
    check("R5 seen", seen[3], 1);
    check("R9 err sticky", err, 1);
    check("R9 dbg kept", dbg_idx, 1);
  endtask

  task automatic t_dual();
    clear_mem();
    set_line(0, "SE", "IM", "", 8'hEE);
    set_line(1, "SE", "ISM", "", 8'hEE);
    set_line(2, "SM", "IM", "", 8'hEE);
    walk("R6");
    check("R6 second reading passes", okv[0], 1);
    check("R6 no second reading", okv[1], 0);
    check("R6 literal reading", okv[2], 1);
    check("R9 dbg idx moves", dbg_idx, 1);
  endtask

  task automatic t_skip();
    clear_mem();
    set_line(0, "ESMI", "ISIE", "", 8'hEE);
    set_line(1, "", "ISIE", "", 8'hEE);
    set_line(2, "EM", "IM", "", 8'hEE);
    walk("R7");
    check("R7 newest I skipped", seen[0], 0);
    check("R7 empty skipped", seen[1], 0);
    check("R7 checked line", seen[2], 1);
    check("R7 checked ok", okv[2], 1);
    check("R7 line3 empty skipped", seen[3], 0);
  endtask

  task automatic t_trigger();
    int d0;
    d0 = n_done;
    repeat (300) @(negedge clk);
    check("R8 no trigger", longint'(n_done - d0), 0);
    check("R8 idle", busy, 0);
    interval = 16'd60;
    repeat (200) @(negedge clk);
    check("R8 interval walk", longint'(n_done > d0), 1);
    interval = '0;
    while (busy) @(negedge clk);
    d0 = n_done;
    repeat (300) @(negedge clk);
    check("R8 interval off", longint'(n_done - d0), 0);
  endtask

  initial begin
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wildcard();
    t_rules();
    t_dual();
    t_skip();
    t_trigger();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule